// File: doc/BRIEF.md
# Signed Fixed-Point Stack ALU

This block holds a small stack of signed two's-complement words and runs integer arithmetic on its top two entries. The top entry is called A and the entry beneath it B. Operands are loaded with a push port. An 8-bit command byte then selects addition, subtraction, sign change, or a multiply that keeps either the low or the high half of the double-width product. The top two entries are always visible on the outputs, together with sign, zero, carry and overflow flags.

Binary operations consume A and B, put the result R where B was, and move the deeper entries up one place, so R ends up on top. The old A wraps into the bottom slot. Sign change replaces A in place. Add, subtract and sign change finish one cycle after the command is accepted. Both multiplies run on a sequential shift-add unit that needs one cycle per operand bit. The most significant bit of the command byte asks for a service-request flag once the command completes.

Top module: `stk_fixed_alu`

## Requirements
- R1: Bits 6:0 of `cmd_byte` select the operation: 0x2C add, 0x2D subtract, 0x34 sign change, 0x2E lower multiply, 0x36 upper multiply. Any other value is ignored: `busy` stays low and the stack is unchanged.
- R2: A push is taken when the block is idle and no legal command is taken in the same cycle. It places `push_data` on top and shifts every entry down one place, dropping the bottom entry. `tos` and `nos` show entries 0 and 1.
- R3: Sign change writes 0 − A to the top and leaves every other entry unchanged. When A is the most negative value (0x80000000), the top is kept as it was and overflow is set.
- R4: Add writes B + A. The carry flag receives the carry out of the unsigned 32-bit sum. On signed overflow, the low 32 bits are returned and overflow is set.
- R5: Subtract writes B − A. The carry flag is 1 on a borrow (B below A as unsigned numbers). Overflow is set when A is 0x80000000 or when the signed difference is out of range, and the low 32 bits are returned.
- R6: After any binary operation, R is on top. The entries that were below B move up one place, and the old A goes into the bottom slot.
- R7: Lower multiply returns the low 32 bits of the signed product A×B. Overflow is set when the upper 32 bits of that product are non-zero. When either operand is 0x80000000, R is 0x80000000 and overflow is set.
- R8: Upper multiply returns the high 32 bits of the signed product. Overflow is set when either operand is 0x80000000, and R is then unspecified.
- R9: On completion, zero is set when R is 0 and sign copies bit 31 of R. Carry is 0 for the sign change and both multiplies. Overflow is 0 unless the rules of R3, R4, R5, R7 and R8 set it. The flags keep their value through pushes and until the next completion.
- R10: `busy` goes high in the cycle after a command is accepted. It stays high for 1 cycle for add, subtract and sign change, and for W+1 (33) cycles for either multiply.
- R11: Commands and pushes presented while `busy` is high are ignored.
- R12: When a command completes with bit 7 of its byte set, `svc_req` goes high and stays high until the next command is accepted. A command with bit 7 clear leaves `svc_req` low.
- R13: After reset, all stack entries and all flags are 0, and `busy` and `svc_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_byte | input | 8 | Bit 7 service-request enable, bits 6:0 operation code |
| push_valid | input | 1 | Push request |
| push_data | input | W | Word to push onto the stack |
| busy | output | 1 | A command is executing |
| tos | output | W | Stack entry 0 (A) |
| nos | output | W | Stack entry 1 (B) |
| flag_sign | output | 1 | Bit 31 of the last result |
| flag_zero | output | 1 | Last result was zero |
| flag_carry | output | 1 | Carry out (add) or borrow (subtract) |
| flag_ovf | output | 1 | Overflow per operation rules |
| svc_req | output | 1 | Service request after a flagged command |

## Verification
A vector table drives each operation with operand pairs chosen to isolate one flag rule at a time.

- Add is tried with an ordinary sum, an unsigned wrap that only sets carry, a signed wrap that only sets overflow, and a case that sets both.
- Subtract is tried with a borrow without overflow, and with a most-negative subtrahend whose result still fits. This separates the explicit minimum-operand rule from the general range check.
- The multiplies are tried with small positive products, a product of two negatives, and a negative product with a small magnitude. The last case sets overflow only because the upper half is all ones, which tells the non-zero rule apart from a sign-extension rule.
- A product of exactly 2^32 and minimum-value operands are also used.

Directed tests follow. They check the stack rotation over successive adds, the busy duration, commands and pushes ignored while busy, illegal codes, flag retention over pushes, and the lifetime of the service request.

// File: rtl/stk_alu_pkg.sv
package stk_alu_pkg;

    // Operation codes carried in bits 6:0 of the command byte
    localparam logic [6:0] CODE_ADD  = 7'h2C;
    localparam logic [6:0] CODE_SUB  = 7'h2D;
    localparam logic [6:0] CODE_MULL = 7'h2E;
    localparam logic [6:0] CODE_NEG  = 7'h34;
    localparam logic [6:0] CODE_MULU = 7'h36;

    typedef enum logic [2:0] {
        OP_ADD,
        OP_SUB,
        OP_NEG,
        OP_MULL,
        OP_MULU
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALU,
        ST_MUL
    } seq_st_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic carry;
        logic ovf;
    } flags_t;

endpackage

// File: rtl/stk_cmd_decode.sv
module stk_cmd_decode
    import stk_alu_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output logic       legal,
    output alu_op_e    op,
    output logic       svc_en
);

    always_comb begin
        svc_en = cmd_byte[7];
        legal  = 1'b1;
        op     = OP_ADD;
        case (cmd_byte[6:0])
            CODE_ADD:  op = OP_ADD;
            CODE_SUB:  op = OP_SUB;
            CODE_NEG:  op = OP_NEG;
            CODE_MULL: op = OP_MULL;
            CODE_MULU: op = OP_MULU;
            default:   legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/stk_addsub.sv
module stk_addsub
    import stk_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           carry,
    output logic           ovf
);

    localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum_w;
    logic [W:0] diff_w;
    logic       a_is_min;

    always_comb begin
        sum_w    = {1'b0, b} + {1'b0, a};
        diff_w   = {1'b0, b} - {1'b0, a};
        a_is_min = (a == MIN_VAL);
        res      = '0;
        carry    = 1'b0;
        ovf      = 1'b0;
        case (op)
            OP_ADD: begin
                res   = sum_w[W-1:0];
                carry = sum_w[W];
                ovf   = (a[W-1] == b[W-1]) && (sum_w[W-1] != b[W-1]);
            end
            OP_SUB: begin
                res   = diff_w[W-1:0];
                carry = diff_w[W];
                ovf   = a_is_min ||
                        ((a[W-1] != b[W-1]) && (diff_w[W-1] != b[W-1]));
            end
            OP_NEG: begin
                if (a_is_min) begin
                    res = a;
                    ovf = 1'b1;
                end else begin
                    res = '0 - a;
                end
            end
            default: begin
                res = '0;
            end
        endcase
    end

endmodule

// File: rtl/stk_seq_mul.sv
module stk_seq_mul #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           done,
    output logic [2*W-1:0] prod
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic             run;
        logic             done;
        logic             neg;
        logic [CW-1:0]    cnt;
        logic [2*W-1:0]   acc;
        logic [2*W-1:0]   mcand;
        logic [W-1:0]     mplier;
    } mul_reg_t;

    mul_reg_t m_q, m_d;
    logic [W-1:0] a_mag, b_mag;

    always_comb begin
        a_mag = a[W-1] ? (~a + 1'b1) : a;
        b_mag = b[W-1] ? (~b + 1'b1) : b;
        m_d      = m_q;
        m_d.done = 1'b0;
        if (start) begin
            m_d.run    = 1'b1;
            m_d.cnt    = '0;
            m_d.acc    = '0;
            m_d.mcand  = {{W{1'b0}}, b_mag};
            m_d.mplier = a_mag;
            m_d.neg    = a[W-1] ^ b[W-1];
        end else if (m_q.run) begin
            if (m_q.mplier[0]) begin
                m_d.acc = m_q.acc + m_q.mcand;
            end
            m_d.mcand  = m_q.mcand << 1;
            m_d.mplier = m_q.mplier >> 1;
            m_d.cnt    = m_q.cnt + 1'b1;
            if (m_q.cnt == LAST) begin
                m_d.run  = 1'b0;
                m_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign done = m_q.done;
    assign prod = m_q.neg ? (~m_q.acc + 1'b1) : m_q.acc;

    AST_MUL_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.done |=> !m_q.done); // R10
    AST_MUL_RUN_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (m_q.run && m_q.cnt == '0)); // R10
    AST_MUL_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (!m_q.run && !m_q.done)); // R11

endmodule

// File: rtl/stk_fixed_alu.sv
module stk_fixed_alu
    import stk_alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [7:0]   cmd_byte,
    input  logic         push_valid,
    input  logic [W-1:0] push_data,
    output logic         busy,
    output logic [W-1:0] tos,
    output logic [W-1:0] nos,
    output logic         flag_sign,
    output logic         flag_zero,
    output logic         flag_carry,
    output logic         flag_ovf,
    output logic         svc_req
);

    localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        seq_st_e                   st;
        alu_op_e                   op;
        logic                      sr;
        logic [DEPTH-1:0][W-1:0]   stk;
        flags_t                    flg;
        logic                      svc;
    } top_reg_t;

    top_reg_t r_q, r_d;

    logic           dec_legal;
    alu_op_e        dec_op;
    logic           dec_sr;
    logic           accept;
    logic           push_ok;
    logic           mul_start;
    logic           mul_done;
    logic [2*W-1:0] mul_prod;
    logic [W-1:0]   as_res;
    logic           as_carry;
    logic           as_ovf;
    logic [W-1:0]   fin_res;
    logic           fin_carry;
    logic           fin_ovf;
    logic           op_min;
    logic           finish;

    stk_cmd_decode i_dec (
        .cmd_byte (cmd_byte),
        .legal    (dec_legal),
        .op       (dec_op),
        .svc_en   (dec_sr)
    );

    stk_addsub #(.W(W)) i_addsub (
        .op    (r_q.op),
        .a     (r_q.stk[0]),
        .b     (r_q.stk[1]),
        .res   (as_res),
        .carry (as_carry),
        .ovf   (as_ovf)
    );

    stk_seq_mul #(.W(W)) i_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .a     (r_q.stk[0]),
        .b     (r_q.stk[1]),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    assign accept    = (r_q.st == ST_IDLE) && cmd_valid && dec_legal;
    assign push_ok   = (r_q.st == ST_IDLE) && push_valid && !accept;
    assign mul_start = accept && ((dec_op == OP_MULL) || (dec_op == OP_MULU));
    assign finish    = (r_q.st == ST_ALU) || ((r_q.st == ST_MUL) && mul_done);

    // Result selection at completion
    always_comb begin
        op_min    = (r_q.stk[0] == MIN_VAL) || (r_q.stk[1] == MIN_VAL);
        fin_res   = as_res;
        fin_carry = as_carry;
        fin_ovf   = as_ovf;
        if (r_q.op == OP_MULL) begin
            fin_carry = 1'b0;
            fin_res   = op_min ? MIN_VAL : mul_prod[W-1:0];
            fin_ovf   = op_min || (mul_prod[2*W-1:W] != '0);
        end else if (r_q.op == OP_MULU) begin
            fin_carry = 1'b0;
            fin_res   = mul_prod[2*W-1:W];
            fin_ovf   = op_min;
        end
    end

    // Next-state computation
    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st  = mul_start ? ST_MUL : ST_ALU;
                    r_d.op  = dec_op;
                    r_d.sr  = dec_sr;
                    r_d.svc = 1'b0;
                end else if (push_ok) begin
                    r_d.stk[0] = push_data;
                    for (int i = 1; i < DEPTH; i++) begin
                        r_d.stk[i] = r_q.stk[i-1];
                    end
                end
            end
            default: begin
                if (finish) begin
                    r_d.stk[0] = fin_res;
                    if (r_q.op != OP_NEG) begin
                        for (int i = 1; i < DEPTH - 1; i++) begin
                            r_d.stk[i] = r_q.stk[i+1];
                        end
                        r_d.stk[DEPTH-1] = r_q.stk[0];
                    end
                    r_d.flg.sign  = fin_res[W-1];
                    r_d.flg.zero  = (fin_res == '0);
                    r_d.flg.carry = fin_carry;
                    r_d.flg.ovf   = fin_ovf;
                    r_d.svc       = r_q.sr;
                    r_d.st        = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign tos        = r_q.stk[0];
    assign nos        = r_q.stk[1];
    assign flag_sign  = r_q.flg.sign;
    assign flag_zero  = r_q.flg.zero;
    assign flag_carry = r_q.flg.carry;
    assign flag_ovf   = r_q.flg.ovf;
    assign svc_req    = r_q.svc;

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && dec_legal) |=> busy); // R10
    AST_ALU_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ALU) |=> !busy); // R10
    AST_HOLD_WHILE_MUL: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_MUL) && !mul_done) |=> $stable(r_q.stk)); // R11
    AST_NEG_MIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_ALU) && (r_q.op == OP_NEG) && (r_q.stk[0] == MIN_VAL))
        |=> ((tos == MIN_VAL) && flag_ovf)); // R3
    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_ALU) && (r_q.op == OP_ADD))
        |=> (tos == $past(r_q.stk[0]) + $past(r_q.stk[1]))); // R4
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (flag_zero == (tos == '0))); // R9
    AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (flag_sign == tos[W-1])); // R9
    AST_SVC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !svc_req); // R12

endmodule

// File: tb/test_stk_fixed_alu.sv
`timescale 1ns/1ps
module test_stk_fixed_alu;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [7:0]  cmd_byte;
    logic        push_valid;
    logic [31:0] push_data;
    logic        busy;
    logic [31:0] tos, nos;
    logic        flag_sign, flag_zero, flag_carry, flag_ovf, svc_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    stk_fixed_alu #(.W(32), .DEPTH(4)) i_stk_fixed_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .push_valid (push_valid),
        .push_data  (push_data),
        .busy       (busy),
        .tos        (tos),
        .nos        (nos),
        .flag_sign  (flag_sign),
        .flag_zero  (flag_zero),
        .flag_carry (flag_carry),
        .flag_ovf   (flag_ovf),
        .svc_req    (svc_req)
    );

    typedef struct packed {
        logic [7:0]  cmd;
        logic [31:0] b;
        logic [31:0] a;
        logic [31:0] r;
        logic        chk_r;
        logic        c;
        logic        v;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{8'h2C, 32'd7,        32'd5,        32'd12,       1'b1, 1'b0, 1'b0},
        '{8'hAC, 32'hFFFFFFFF, 32'd1,        32'd0,        1'b1, 1'b1, 1'b0},
        '{8'h2C, 32'h7FFFFFFF, 32'd1,        32'h80000000, 1'b1, 1'b0, 1'b1},
        '{8'hAC, 32'h80000000, 32'h80000000, 32'd0,        1'b1, 1'b1, 1'b1},
        '{8'h2D, 32'd10,       32'd3,        32'd7,        1'b1, 1'b0, 1'b0},
        '{8'hAD, 32'd3,        32'd10,       32'hFFFFFFF9, 1'b1, 1'b1, 1'b0},
        '{8'h2D, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF, 1'b1, 1'b0, 1'b1},
        '{8'h2D, 32'h80000000, 32'd1,        32'h7FFFFFFF, 1'b1, 1'b0, 1'b1},
        '{8'h34, 32'd9,        32'd5,        32'hFFFFFFFB, 1'b1, 1'b0, 1'b0},
        '{8'hB4, 32'd9,        32'h80000000, 32'h80000000, 1'b1, 1'b0, 1'b1},
        '{8'h34, 32'd9,        32'd0,        32'd0,        1'b1, 1'b0, 1'b0},
        '{8'h2E, 32'd7,        32'd6,        32'd42,       1'b1, 1'b0, 1'b0},
        '{8'hAE, 32'h00010000, 32'h00010000, 32'd0,        1'b1, 1'b0, 1'b1},
        '{8'h2E, 32'hFFFFFFFD, 32'hFFFFFFFC, 32'd12,       1'b1, 1'b0, 1'b0},
        '{8'h2E, 32'hFFFFFFFE, 32'd3,        32'hFFFFFFFA, 1'b1, 1'b0, 1'b1},
        '{8'h2E, 32'd2,        32'h80000000, 32'h80000000, 1'b1, 1'b0, 1'b1},
        '{8'h36, 32'h00010000, 32'h00030000, 32'd3,        1'b1, 1'b0, 1'b0},
        '{8'hB6, 32'hFFFFFFFF, 32'd5,        32'hFFFFFFFF, 1'b1, 1'b0, 1'b0},
        '{8'h36, 32'h40000000, 32'h40000000, 32'h10000000, 1'b1, 1'b0, 1'b0},
        '{8'h36, 32'h80000000, 32'd1,        32'd0,        1'b0, 1'b0, 1'b1}
    };

    function automatic string req_of(input logic [6:0] c);
        case (c)
            7'h2C:   return "R4";
            7'h2D:   return "R5";
            7'h34:   return "R3";
            7'h2E:   return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk);
        push_valid = 1'b1;
        push_data  = d;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    // Issue a command; returns the number of sampled cycles busy was high
    task automatic issue(input logic [7:0] c, output int busy_cycles);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy_cycles = 0;
        while (busy) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int bc;
        logic [31:0] keep;
        rst_n      = 1'b0;
        cmd_valid  = 1'b0;
        cmd_byte   = 8'h00;
        push_valid = 1'b0;
        push_data  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: reset state
        check("R13", "tos", tos, 32'd0);
        check("R13", "nos", nos, 32'd0);
        check("R13", "flags", {28'd0, flag_sign, flag_zero, flag_carry, flag_ovf}, 32'd0);
        check("R13", "busy/svc", {30'd0, busy, svc_req}, 32'd0);

        // Vector table: R3, R4, R5, R7, R8, R9, R12
        for (int k = 0; k < NV; k++) begin
            string rq;
            rq = req_of(VECS[k].cmd[6:0]);
            push(VECS[k].b);
            push(VECS[k].a);
            issue(VECS[k].cmd, bc);
            if (VECS[k].chk_r) begin
                check(rq, "result", tos, VECS[k].r);
                check("R9", "sign", {31'd0, flag_sign}, {31'd0, VECS[k].r[31]});
                check("R9", "zero", {31'd0, flag_zero}, {31'd0, VECS[k].r == 32'd0});
            end
            check(rq, "carry", {31'd0, flag_carry}, {31'd0, VECS[k].c});
            check(rq, "ovf", {31'd0, flag_ovf}, {31'd0, VECS[k].v});
            check("R12", "svc_req", {31'd0, svc_req}, {31'd0, VECS[k].cmd[7]});
            if (VECS[k].cmd[6:0] == 7'h34) begin
                check("R3", "nos unchanged", nos, VECS[k].b);
            end
        end

        // R2 + R6: stack movement over successive adds
        push(32'd1);
        push(32'd2);
        push(32'd3);
        push(32'd4);
        check("R2", "tos after pushes", tos, 32'd4);
        check("R2", "nos after pushes", nos, 32'd3);
        issue(8'h2C, bc);
        check("R6", "tos 4+3", tos, 32'd7);
        check("R6", "nos moved up", nos, 32'd2);
        issue(8'h2C, bc);
        check("R6", "tos 7+2", tos, 32'd9);
        check("R6", "nos moved up", nos, 32'd1);
        issue(8'h2C, bc);
        check("R6", "tos 9+1", tos, 32'd10);
        check("R6", "old A at bottom", nos, 32'd4);

        // R10: busy durations
        push(32'd8);
        push(32'd2);
        issue(8'h2D, bc);
        check("R10", "alu busy cycles", bc, 32'd1);
        check("R5", "8-2", tos, 32'd6);
        push(32'd3);
        push(32'd4);
        issue(8'h34, bc);
        check("R10", "neg busy cycles", bc, 32'd1);
        push(32'd3);
        push(32'd4);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = 8'h2E;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R10", "busy after accept", {31'd0, busy}, 32'd1);
        // R11: command and push during multiply are ignored
        cmd_valid  = 1'b1;
        cmd_byte   = 8'h2C;
        push_valid = 1'b1;
        push_data  = 32'hDEAD0000;
        @(negedge clk);
        cmd_valid  = 1'b0;
        push_valid = 1'b0;
        bc = 1;
        while (busy) begin
            bc++;
            @(negedge clk);
        end
        check("R10", "mul busy cycles", bc, 32'd33);
        check("R11", "mul result kept", tos, 32'd12);
        repeat (2) @(negedge clk);
        check("R11", "no late add", {31'd0, busy}, 32'd0);
        check("R11", "tos still product", tos, 32'd12);

        // R1: illegal codes ignored
        keep = tos;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = 8'h00;
        @(negedge clk);
        cmd_byte  = 8'hFF;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R1", "illegal busy", {31'd0, busy}, 32'd0);
        check("R1", "illegal tos", tos, keep);

        // R9 + R12: flags and service request survive pushes, svc clears on accept
        push(32'd0);
        push(32'd5);
        issue(8'hB4, bc);
        check("R12", "svc set", {31'd0, svc_req}, 32'd1);
        check("R9", "neg sign", {31'd0, flag_sign}, 32'd1);
        push(32'd0);
        check("R9", "sign kept over push", {31'd0, flag_sign}, 32'd1);
        check("R9", "zero kept over push", {31'd0, flag_zero}, 32'd0);
        check("R12", "svc kept over push", {31'd0, svc_req}, 32'd1);
        check("R2", "push placed on top", tos, 32'd0);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = 8'h34;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R12", "svc cleared on accept", {31'd0, svc_req}, 32'd0);
        @(negedge clk);
        check("R9", "neg zero flag", {31'd0, flag_zero}, 32'd1);
        check("R12", "svc stays low", {31'd0, svc_req}, 32'd0);

        // R13: reset mid-run clears state
        push(32'h1234);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13", "tos after reset", tos, 32'd0);
        check("R13", "flags after reset", {28'd0, flag_sign, flag_zero, flag_carry, flag_ovf}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule